// File: doc/BRIEF.md
# Banked Data Memory with Indirect Pointers

This block is the 8-bit data memory of a small microcontroller core. It decodes a register-file address space and holds two memory pointers, a bank selector, the accumulator and general-purpose RAM. Addresses 00h and 02h have no storage of their own. An access to either one is redirected to the RAM address held in pointer 0 or pointer 1.

General RAM has two parts. Addresses 06h to 3Fh form one region that every bank sees. Addresses 40h to 7Fh form a window, and the bank selector decides which physical bank that window shows. The core reads through a combinational read port and writes through a separate write port. Writes commit on the rising clock edge. The accumulator is mapped into the address space, and its value is also driven out for the execution unit.

Top module: `bank_ram_file`

## Requirements
- R1: A write with `wr_en` high is committed at the rising clock edge. Before that edge the read port still shows the previous contents. A read in the same cycle as a write to the same location returns the old value.
- R2: Pointer 0 is stored at 01h and pointer 1 at 03h. Each holds all 8 bits written to it and reads them back.
- R3: An access to 00h uses the address in pointer 0 as the effective address. An access to 02h uses the address in pointer 1. This holds for both reads and writes.
- R4: An indirect read whose pointer holds 00h or 02h returns 00h.
- R5: An indirect write whose pointer holds 00h or 02h changes no storage. This covers the pointers, the bank selector, the accumulator and all RAM.
- R6: The bank selector is stored at 04h. Only bit 0 is kept, and bits 7:1 read as 0. Bit 0 chooses which of two 64-byte banks appears at 40h–7Fh. Writing 0 selects bank 0.
- R7: Addresses 06h–3Fh reach the same storage whatever the bank selector holds.
- R8: The accumulator is stored at 05h and its value is driven on `acc_o`.
- R9: Addresses 80h–FFh read as 00h. Writes to them have no effect.
- R10: After reset, every pointer, the bank selector, the accumulator and all RAM read as 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| acc_o | output | 8 | Current accumulator value |

## Verification
The bench aims at redirection through a pointer that holds 00h or 02h. A design that recursed, or that treated the pseudo-address as storage, would return stale data or corrupt a register on the ignored write. It switches banks between writes and reads to the same offset. It also checks that 06h–3Fh stays common to both banks, so a decoder with the wrong region boundary would show bank-dependent data in the shared region. Pointers are aimed at the pointer registers, the bank selector and unmapped space. Same-cycle read/write collisions are exercised, so a read port that bypassed the write data would show the new value one cycle early.

// File: rtl/bank_ram_file.sv
module bank_ram_file #(
  parameter int WIDTH      = 8,
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] acc_o
);

  localparam int BIW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int OFW = $clog2(BANK_BYTES);
  localparam int BKW = BIW + OFW;
  localparam logic [WIDTH-1:0] A_IND0 = WIDTH'(0);
  localparam logic [WIDTH-1:0] A_PTR0 = WIDTH'(1);
  localparam logic [WIDTH-1:0] A_IND1 = WIDTH'(2);
  localparam logic [WIDTH-1:0] A_PTR1 = WIDTH'(3);
  localparam logic [WIDTH-1:0] A_BANK = WIDTH'(4);
  localparam logic [WIDTH-1:0] A_ACC  = WIDTH'(5);
  localparam logic [WIDTH-1:0] A_LO   = WIDTH'(6);
  localparam logic [WIDTH-1:0] A_BASE = WIDTH'(BANK_BYTES);
  localparam logic [WIDTH-1:0] A_LAST = WIDTH'(2 * BANK_BYTES - 1);

  logic [WIDTH-1:0] ptr0_q, ptr1_q, acc_q;
  logic [BIW-1:0]   bank_q;
  logic [WIDTH-1:0] shr_q [BANK_BYTES];
  logic [WIDTH-1:0] bnk_q [NUM_BANKS*BANK_BYTES];

  logic             rd_ind, rd_loop, wr_ind, wr_loop;
  logic [WIDTH-1:0] rd_eff, wr_eff;

  assign rd_ind  = (rd_addr == A_IND0) || (rd_addr == A_IND1);
  assign rd_eff  = (rd_addr == A_IND0) ? ptr0_q : (rd_addr == A_IND1) ? ptr1_q : rd_addr;
  assign rd_loop = rd_ind && ((rd_eff == A_IND0) || (rd_eff == A_IND1));

  assign wr_ind  = (wr_addr == A_IND0) || (wr_addr == A_IND1);
  assign wr_eff  = (wr_addr == A_IND0) ? ptr0_q : (wr_addr == A_IND1) ? ptr1_q : wr_addr;
  assign wr_loop = wr_ind && ((wr_eff == A_IND0) || (wr_eff == A_IND1));

  logic [BKW-1:0] rd_bidx, wr_bidx;
  assign rd_bidx = {bank_q, rd_eff[OFW-1:0]};
  assign wr_bidx = {bank_q, wr_eff[OFW-1:0]};

  always_comb begin
    rd_data = '0;
    if (!rd_loop) begin
      if (rd_eff == A_PTR0)                        rd_data = ptr0_q;
      else if (rd_eff == A_PTR1)                   rd_data = ptr1_q;
      else if (rd_eff == A_BANK)                   rd_data = WIDTH'(bank_q);
      else if (rd_eff == A_ACC)                    rd_data = acc_q;
      else if (rd_eff >= A_LO && rd_eff < A_BASE)  rd_data = shr_q[rd_eff[OFW-1:0]];
      else if (rd_eff >= A_BASE && rd_eff <= A_LAST) rd_data = bnk_q[rd_bidx];
    end
  end

  assign acc_o = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr0_q <= '0;
      ptr1_q <= '0;
      bank_q <= '0;
      acc_q  <= '0;
      for (int i = 0; i < BANK_BYTES; i++) shr_q[i] <= '0;
      for (int i = 0; i < NUM_BANKS*BANK_BYTES; i++) bnk_q[i] <= '0;
    end else if (wr_en && !wr_loop) begin
      if (wr_eff == A_PTR0)                          ptr0_q <= wr_data;
      else if (wr_eff == A_PTR1)                     ptr1_q <= wr_data;
      else if (wr_eff == A_BANK)                     bank_q <= wr_data[BIW-1:0];
      else if (wr_eff == A_ACC)                      acc_q  <= wr_data;
      else if (wr_eff >= A_LO && wr_eff < A_BASE)    shr_q[wr_eff[OFW-1:0]] <= wr_data;
      else if (wr_eff >= A_BASE && wr_eff <= A_LAST) bnk_q[wr_bidx] <= wr_data;
    end
  end

  // R4
  p_loop_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_loop |-> rd_data == '0);

  // R5
  p_loop_write_inert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_loop) |=> ($stable(ptr0_q) && $stable(ptr1_q) && $stable(bank_q) && $stable(acc_q)));

  // R2
  p_ptr0_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_PTR0) |=> ptr0_q == $past(wr_data));

  // R6
  p_bank_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_BANK) |-> rd_data[WIDTH-1:BIW] == '0);

  // R8
  p_acc_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_ACC) |-> rd_data == acc_o);

  // R9
  p_high_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr > A_LAST) |-> rd_data == '0);

  // R9
  p_high_write_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > A_LAST) |=> ($stable(ptr0_q) && $stable(ptr1_q) && $stable(acc_q)));

endmodule

// File: tb/bank_ram_file_bench.sv
module bank_ram_file_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] rd_addr = 0, wr_addr = 0, wr_data = 0;
  logic       wr_en = 0;
  logic [7:0] rd_data, acc_o;

  bank_ram_file u_bank_ram_file (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .acc_o(acc_o)
  );

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] m_p0 = 0, m_p1 = 0, m_acc = 0;
  int m_bank = 0;
  logic [7:0] m_shr [64];
  logic [7:0] m_bnk [2][64];
  int unsigned seed = 32'h1234_5678;

  function automatic int unsigned rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  function automatic int target(input logic [7:0] a, output bit loopy);
    int t = a;
    loopy = 0;
    if (a == 0) t = m_p0;
    else if (a == 2) t = m_p1;
    if ((a == 0 || a == 2) && (t == 0 || t == 2)) loopy = 1;
    return t;
  endfunction

  function automatic logic [7:0] m_read(input logic [7:0] a);
    bit lp; int t = target(a, lp);
    if (lp) return 8'h00;
    if (t == 1) return m_p0;
    if (t == 3) return m_p1;
    if (t == 4) return 8'(m_bank);
    if (t == 5) return m_acc;
    if (t >= 6 && t < 64) return m_shr[t];
    if (t >= 64 && t < 128) return m_bnk[m_bank][t-64];
    return 8'h00;
  endfunction

  function automatic void m_write(input logic [7:0] a, input logic [7:0] d);
    bit lp; int t = target(a, lp);
    if (lp) return;
    if (t == 1) m_p0 = d;
    else if (t == 3) m_p1 = d;
    else if (t == 4) m_bank = d & 1;
    else if (t == 5) m_acc = d;
    else if (t >= 6 && t < 64) m_shr[t] = d;
    else if (t >= 64 && t < 128) m_bnk[m_bank][t-64] = d;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    bit lp; int t = target(a, lp);
    if (lp) return "R4";
    if (a == 0 || a == 2) return "R3";
    if (t == 1 || t == 3) return "R2";
    if (t == 4 || (t >= 64 && t < 128)) return "R6";
    if (t == 5) return "R8";
    if (t >= 6 && t < 64) return "R7";
    return "R9";
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic op(input logic [7:0] ra, input logic we, input logic [7:0] wa,
                    input logic [7:0] wd, input string req);
    @(negedge clk);
    rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd;
    #1;
    check(rd_data, m_read(ra), (req == "") ? tag_of(ra) : req);
    check(acc_o, m_acc, "R8");
    @(posedge clk);
    if (we) m_write(wa, wd);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    op(8'h00, 1'b1, a, d, "");
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    op(a, 1'b0, 8'h00, 8'h00, req);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      m_shr[i] = 0; m_bnk[0][i] = 0; m_bnk[1][i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    rd_addr = 8'h01; #1; check(rd_data, 8'h00, "R10");
    rd_addr = 8'h05; #1; check(rd_data, 8'h00, "R10");
    rst_n = 1;
    for (int a = 0; a < 256; a += 17) rd(8'(a), "R10");

    // R1 direct write then read, collision returns old value
    op(8'h10, 1'b1, 8'h10, 8'hA5, "R1");
    op(8'h10, 1'b1, 8'h10, 8'h5A, "R1");
    rd(8'h10, "R1");

    // R2 pointers
    wr(8'h01, 8'hFF); rd(8'h01, "R2");
    wr(8'h03, 8'h81); rd(8'h03, "R2");

    // R3 indirect read/write via each pointer
    wr(8'h01, 8'h20); wr(8'h00, 8'h3C); rd(8'h20, "R3"); rd(8'h00, "R3");
    wr(8'h03, 8'h45); wr(8'h02, 8'hC3); rd(8'h45, "R3"); rd(8'h02, "R3");
    wr(8'h03, 8'h01); wr(8'h02, 8'h07); rd(8'h01, "R3");

    // R4/R5 indirect-on-indirect
    wr(8'h01, 8'h02); wr(8'h03, 8'h00);
    wr(8'h05, 8'h77);
    rd(8'h00, "R4"); rd(8'h02, "R4");
    wr(8'h00, 8'hEE); wr(8'h02, 8'hDD);
    rd(8'h01, "R5"); rd(8'h03, "R5"); rd(8'h04, "R5"); rd(8'h05, "R5");
    rd(8'h45, "R5"); rd(8'h20, "R5");

    // R6 banks, R7 shared region
    wr(8'h04, 8'hFF); rd(8'h04, "R6");
    wr(8'h50, 8'h11); wr(8'h30, 8'h99);
    wr(8'h04, 8'h00); rd(8'h04, "R6"); rd(8'h50, "R6");
    wr(8'h50, 8'h22); rd(8'h30, "R7");
    wr(8'h04, 8'h01); rd(8'h50, "R6"); rd(8'h30, "R7");
    rd(8'h7F, "R6");

    // R8 accumulator, R9 unmapped
    wr(8'h05, 8'h3E); rd(8'h05, "R8");
    wr(8'h80, 8'h12); wr(8'hFF, 8'h34); rd(8'h80, "R9"); rd(8'hFF, "R9");

    for (int n = 0; n < 4000; n++) begin
      int unsigned r = rnd();
      logic [7:0] ra = (r[0]) ? 8'(r[15:8]) : 8'(r[10:8] & 3'h7);
      logic [7:0] wa = (r[1]) ? 8'(r[23:16] & 8'h7F) : 8'(r[18:16]);
      logic [7:0] wd = (r[2]) ? 8'(r[31:24]) : 8'(r[26:24] & 3'h3);
      op(ra, r[3] | r[4], wa, wd, "");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule